// File: doc/BRIEF.md
# Per-Unit Power-Down Reset Sequencer

This block brings a set of compute units into and out of a powered-down, held-in-reset condition under software control. Each unit has one 32-bit control and status word on a small register bus, at byte offset four times the unit index. Software sets the request bit of a word to ask for the unit to be shut down and held in reset. It clears the bit to bring the unit back. It then polls two read-only flags in the same word until the unit reports that it is fully off or fully active.

Each populated unit runs its own sequencer. Shutting down takes a drain phase before the unit is off. Waking takes a power ramp phase and then a long built-in self-test phase before the unit is released from reset. The lengths of the phases are parameters given in clock cycles and stand in for the real power switches and self-test engine. A parameter mask selects which of up to 32 slots hold a unit. The bus interface decodes every access against that mask.

Top module: `pdseq_ctrl`

## Requirements
- R1: After reset, every populated unit is active: its word reads 0x2000_0000 (request bit 0 clear, off flag bit 27 clear, active flag bit 29 set), its `unit_rst` bit is 0 and its `unit_pwr_en` bit is 1.
- R2: A write or read with `bus_sel`=1 reaches the word of unit n only when `bus_addr` equals 4×n and bit n of `UNIT_MASK` is set. An access to a misaligned address or to an unpopulated slot changes no state and reads 0. An unpopulated slot drives `unit_rst`=1 and `unit_pwr_en`=0 at all times.
- R3: Writing bit 0 = 1 to an active unit starts the drain phase at the next clock edge. Drain lasts exactly `PD_CYCLES` cycles, after which the unit is off and its word reads 0x0800_0001. Bit 27 reads 1 only while the unit is off.
- R4: Writing bit 0 = 0 to an off unit starts the ramp phase at the next clock edge. Ramp lasts `PU_CYCLES` cycles, then self-test lasts `BIST_CYCLES` cycles, then the unit is active. Bit 29 reads 1 only while the unit is active.
- R5: `unit_rst` of a populated unit is 1 exactly when its bit 29 reads 0. `unit_pwr_en` is 0 exactly during drain and while off.
- R6: A change of the request bit during drain, ramp or self-test does not cut that phase short. When the phase ends, the unit heads toward the newly requested state: from drain to ramp if the request is clear, and from ramp or self-test to drain if the request is set.
- R7: Each unit's request bit and sequence are unaffected by accesses to other units' words.
- R8: Only bit 0 of a write is stored. A read returns the stored request in bit 0, the off flag in bit 27, the active flag in bit 29, and 0 in all other bits.
- R9: `bus_rdata` is 0 in any cycle without a read (`bus_sel`=0 or `bus_we`=1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the block (4 × unit index) |
| bus_wdata | input | 32 | Write data; only bit 0 is used |
| bus_rdata | output | 32 | Read data, combinational from address and state |
| unit_rst | output | NUM_SLOTS | Active-high reset for each unit |
| unit_pwr_en | output | NUM_SLOTS | Active-high power enable for each unit |

## Verification
The assertions assume that reset is held long enough for every unit to settle in the active state. They also assume the bus carries at most one access per cycle and that addresses stay within the decoded range. The bench drives the bus only between clock edges and from a single process, with one write or read per call. The bench deliberately includes misaligned and unpopulated addresses, which the design must ignore. The phase lengths are shortened so that request flips can be placed inside drain, ramp and self-test while the reference model tracks every unit each cycle.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

    // Sequencer states of one unit
    typedef enum logic [2:0] {
        U_ACTIVE   = 3'd0,
        U_DRAIN    = 3'd1,
        U_OFF      = 3'd2,
        U_RAMP     = 3'd3,
        U_SELFTEST = 3'd4
    } unit_state_e;

    // Bit positions software relies on inside each unit word
    localparam int REQ_BIT = 0;
    localparam int OFF_BIT = 27;
    localparam int ON_BIT  = 29;

    typedef logic [31:0] word_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pdseq_decode.sv
module pdseq_decode #(
    parameter int          NUM_SLOTS = 32,
    parameter logic [31:0] UNIT_MASK = 32'h0000_1FFF,
    localparam int         IDX_W     = (NUM_SLOTS < 2) ? 1 : $clog2(NUM_SLOTS),
    localparam int         ADDR_W    = IDX_W + 2
) (
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [NUM_SLOTS-1:0] wr_en,
    output logic                 rd_hit,
    output logic [IDX_W-1:0]     rd_idx
);

    logic [IDX_W-1:0] idx;
    logic             hit;

    always_comb begin
        idx = bus_addr[ADDR_W-1:2];
        hit = bus_sel && (bus_addr[1:0] == 2'b00)
              && (32'(idx) < NUM_SLOTS) && UNIT_MASK[idx];
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_wr
        assign wr_en[g] = hit && bus_we && (idx == IDX_W'(g));
    end

    assign rd_hit = hit && !bus_we;
    assign rd_idx = idx;

endmodule

// File: rtl/pdseq_unit.sv
module pdseq_unit
    import pdseq_pkg::*;
#(
    parameter int PD_CYCLES   = 16,
    parameter int PU_CYCLES   = 8,
    parameter int BIST_CYCLES = 2000000,
    localparam int MAX_DUR    = max3(PD_CYCLES, PU_CYCLES, BIST_CYCLES),
    localparam int CNT_W      = (MAX_DUR < 2) ? 1 : $clog2(MAX_DUR)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  logic  wr_bit,
    output word_t word,
    output logic  unit_rst,
    output logic  unit_pwr_en
);

    localparam logic [CNT_W-1:0] PD_LOAD   = CNT_W'(PD_CYCLES - 1);
    localparam logic [CNT_W-1:0] PU_LOAD   = CNT_W'(PU_CYCLES - 1);
    localparam logic [CNT_W-1:0] BIST_LOAD = CNT_W'(BIST_CYCLES - 1);

    typedef struct packed {
        unit_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic             req;
    } unit_reg_t;

    unit_reg_t r_q, r_d;
    logic      step_done;

    always_comb begin
        r_d       = r_q;
        step_done = (r_q.cnt == '0);
        if (wr_en) begin
            r_d.req = wr_bit;
        end
        case (r_q.st)
            U_ACTIVE: begin
                if (r_q.req) begin
                    r_d.st  = U_DRAIN;
                    r_d.cnt = PD_LOAD;
                end
            end
            U_DRAIN: begin
                if (!step_done) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (r_q.req) begin
                    r_d.st = U_OFF;
                end else begin
                    r_d.st  = U_RAMP;
                    r_d.cnt = PU_LOAD;
                end
            end
            U_OFF: begin
                if (!r_q.req) begin
                    r_d.st  = U_RAMP;
                    r_d.cnt = PU_LOAD;
                end
            end
            U_RAMP: begin
                if (!step_done) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (r_q.req) begin
                    r_d.st  = U_DRAIN;
                    r_d.cnt = PD_LOAD;
                end else begin
                    r_d.st  = U_SELFTEST;
                    r_d.cnt = BIST_LOAD;
                end
            end
            U_SELFTEST: begin
                if (!step_done) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (r_q.req) begin
                    r_d.st  = U_DRAIN;
                    r_d.cnt = PD_LOAD;
                end else begin
                    r_d.st = U_ACTIVE;
                end
            end
            default: begin
                r_d.st  = U_ACTIVE;
                r_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: U_ACTIVE, cnt: '0, req: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        word          = '0;
        word[REQ_BIT] = r_q.req;
        word[OFF_BIT] = (r_q.st == U_OFF);
        word[ON_BIT]  = (r_q.st == U_ACTIVE);
    end

    assign unit_rst    = (r_q.st != U_ACTIVE);
    assign unit_pwr_en = !((r_q.st == U_DRAIN) || (r_q.st == U_OFF));

endmodule

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
    import pdseq_pkg::*;
#(
    parameter int          NUM_SLOTS   = 32,
    parameter logic [31:0] UNIT_MASK   = 32'h0000_1FFF,
    parameter int          PD_CYCLES   = 16,
    parameter int          PU_CYCLES   = 8,
    parameter int          BIST_CYCLES = 2000000,
    localparam int         IDX_W       = (NUM_SLOTS < 2) ? 1 : $clog2(NUM_SLOTS),
    localparam int         ADDR_W      = IDX_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_SLOTS-1:0] unit_rst,
    output logic [NUM_SLOTS-1:0] unit_pwr_en
);

    logic [NUM_SLOTS-1:0] wr_en;
    logic                 rd_hit;
    logic [IDX_W-1:0]     rd_idx;
    word_t                words [NUM_SLOTS];
    logic                 unused_wdata;

    assign unused_wdata = ^bus_wdata[31:1];

    pdseq_decode #(
        .NUM_SLOTS (NUM_SLOTS),
        .UNIT_MASK (UNIT_MASK)
    ) i_decode (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .wr_en    (wr_en),
        .rd_hit   (rd_hit),
        .rd_idx   (rd_idx)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        if (UNIT_MASK[g]) begin : g_unit
            pdseq_unit #(
                .PD_CYCLES   (PD_CYCLES),
                .PU_CYCLES   (PU_CYCLES),
                .BIST_CYCLES (BIST_CYCLES)
            ) i_unit (
                .clk         (clk),
                .rst_n       (rst_n),
                .wr_en       (wr_en[g]),
                .wr_bit      (bus_wdata[REQ_BIT]),
                .word        (words[g]),
                .unit_rst    (unit_rst[g]),
                .unit_pwr_en (unit_pwr_en[g])
            );
        end else begin : g_empty
            // unpopulated slot: held off and in reset
            assign words[g]       = '0;
            assign unit_rst[g]    = 1'b1;
            assign unit_pwr_en[g] = 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            bus_rdata = words[rd_idx];
        end
    end

endmodule

// File: rtl/pdseq_checker.sv
module pdseq_checker #(
    parameter int NUM_SLOTS = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_we,
    input logic [31:0]          bus_rdata,
    input logic [NUM_SLOTS-1:0] unit_rst,
    input logic [NUM_SLOTS-1:0] unit_pwr_en
);

    localparam logic [31:0] RSVD_MASK = ~32'h2800_0001;

    p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |-> (bus_rdata == 32'h0))
        else $error("read data not zero outside a read");

    p_reserved_bits_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & RSVD_MASK) == 32'h0)
        else $error("reserved read bit set");

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
        p_unpowered_in_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !unit_pwr_en[g] |-> unit_rst[g])
            else $error("unit %0d unpowered but out of reset", g);

        p_reset_entry_drains_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(unit_rst[g]) |-> !unit_pwr_en[g])
            else $error("unit %0d left active without draining", g);

        p_release_after_powered_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(unit_rst[g]) |-> $past(unit_pwr_en[g]))
            else $error("unit %0d released from reset while unpowered", g);

        p_power_up_under_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(unit_pwr_en[g]) |-> unit_rst[g])
            else $error("unit %0d powered up outside reset", g);
    end

endmodule

bind pdseq_ctrl pdseq_checker #(.NUM_SLOTS(NUM_SLOTS)) i_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_rdata   (bus_rdata),
    .unit_rst    (unit_rst),
    .unit_pwr_en (unit_pwr_en)
);

// File: tb/test_pdseq_ctrl.sv
module test_pdseq_ctrl;

    localparam int          CLK_PERIOD = 10;
    localparam int          NSL        = 32;
    localparam logic [31:0] MASK       = 32'h0000_1FFF;
    localparam int          PD         = 3;
    localparam int          PU         = 2;
    localparam int          BIST       = 6;
    localparam int          AW         = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NSL-1:0]  unit_rst;
    logic [NSL-1:0]  unit_pwr_en;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    timed_out = 0;
    string phase = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pdseq_ctrl #(
        .NUM_SLOTS   (NSL),
        .UNIT_MASK   (MASK),
        .PD_CYCLES   (PD),
        .PU_CYCLES   (PU),
        .BIST_CYCLES (BIST)
    ) i_pdseq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .unit_rst    (unit_rst),
        .unit_pwr_en (unit_pwr_en)
    );

    // Reference model. Modes: 0 up, 1 draining, 2 off, 3 ramping, 4 self-testing.
    int m_mode [NSL];
    int m_left [NSL];
    bit m_req  [NSL];

    function automatic int phase_len(input int mode);
        if (mode == 1) return PD;
        if (mode == 3) return PU;
        return BIST;
    endfunction

    function automatic bit addr_ok(input logic [AW-1:0] a);
        return (a[1:0] == 2'b00) && MASK[a[AW-1:2]];
    endfunction

    function automatic logic [31:0] m_word(input int u);
        logic [31:0] w;
        w = '0;
        if (!MASK[u]) return w;
        w[0]  = m_req[u];
        w[27] = (m_mode[u] == 2);
        w[29] = (m_mode[u] == 0);
        return w;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int u = 0; u < NSL; u++) begin
                m_mode[u] = 0;
                m_left[u] = 0;
                m_req[u]  = 0;
            end
        end else begin
            for (int u = 0; u < NSL; u++) begin
                if (MASK[u]) begin
                    int nxt;
                    nxt = m_mode[u];
                    if (m_mode[u] == 0) begin
                        if (m_req[u]) nxt = 1;
                    end else if (m_mode[u] == 2) begin
                        if (!m_req[u]) nxt = 3;
                    end else begin
                        m_left[u] = m_left[u] - 1;
                        if (m_left[u] == 0) begin
                            if (m_mode[u] == 1) nxt = m_req[u] ? 2 : 3;
                            else if (m_mode[u] == 3) nxt = m_req[u] ? 1 : 4;
                            else nxt = m_req[u] ? 1 : 0;
                        end
                    end
                    if (nxt != m_mode[u] && (nxt == 1 || nxt == 3 || nxt == 4))
                        m_left[u] = phase_len(nxt);
                    m_mode[u] = nxt;
                end
            end
            if (bus_sel && bus_we && addr_ok(bus_addr))
                m_req[bus_addr[AW-1:2]] = bus_wdata[0];
        end
    end

    task automatic check32(input string tag, input string what,
                           input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic compare_all();
        logic [NSL-1:0] e_rst, e_en;
        logic [31:0]    e_rd;
        for (int u = 0; u < NSL; u++) begin
            e_rst[u] = MASK[u] ? (m_mode[u] != 0) : 1'b1;
            e_en[u]  = MASK[u] ? !(m_mode[u] == 1 || m_mode[u] == 2) : 1'b0;
        end
        e_rd = (bus_sel && !bus_we && addr_ok(bus_addr)) ? m_word(bus_addr[AW-1:2]) : 32'h0;
        check32({phase, "/R5"}, "unit_rst", unit_rst, e_rst);
        check32({phase, "/R5"}, "unit_pwr_en", unit_pwr_en, e_en);
        check32({phase, "/R9"}, "bus_rdata", bus_rdata, e_rd);
    endtask

    task automatic cyc();
        @(negedge clk);
        if (rst_n) compare_all();
    endtask

    task automatic idle(input int n);
        repeat (n) cyc();
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        cyc();
        bus_sel = 1'b1; bus_we = 1'b1;
        bus_addr = AW'(addr); bus_wdata = data;
        cyc();
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int addr, input logic [31:0] exp, input string tag);
        cyc();
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(addr);
        #1;
        check32(tag, "read word", bus_rdata, exp);
        cyc();
        bus_sel = 1'b0;
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        phase = "R1";
        idle(2);
        rd(0, 32'h2000_0000, "R1");
        rd(4 * 12, 32'h2000_0000, "R1");
        check32("R1", "unit_rst low bits", {19'h0, unit_rst[12:0]}, 32'h0);
        // R3: drain then off
        phase = "R3";
        wr(4, 32'h1);
        idle(8);
        rd(4, 32'h0800_0001, "R3");
        // R4: ramp, self-test, active
        phase = "R4";
        wr(4, 32'h0);
        idle(3);
        rd(4, 32'h0000_0000, "R4");
        idle(10);
        rd(4, 32'h2000_0000, "R4");
        // R6: request flips inside each phase
        phase = "R6";
        wr(8, 32'h1);
        wr(8, 32'h0);
        idle(15);
        rd(8, 32'h2000_0000, "R6");
        wr(12, 32'h1);
        idle(6);
        wr(12, 32'h0);
        idle(3);
        wr(12, 32'h1);
        idle(20);
        rd(12, 32'h0800_0001, "R6");
        wr(12, 32'h0);
        wr(12, 32'h1);
        idle(12);
        rd(12, 32'h0800_0001, "R6");
        wr(12, 32'h0);
        idle(15);
        // R7: overlapping sequences on separate units
        phase = "R7";
        wr(16, 32'h1);
        idle(1);
        wr(20, 32'h1);
        idle(10);
        rd(16, 32'h0800_0001, "R7");
        rd(20, 32'h0800_0001, "R7");
        rd(24, 32'h2000_0000, "R7");
        wr(16, 32'h0);
        idle(12);
        wr(20, 32'h0);
        idle(12);
        // R2: misaligned and unpopulated accesses
        phase = "R2";
        wr(4 * 6 + 1, 32'h1);
        wr(4 * 6 + 2, 32'h1);
        idle(6);
        rd(24, 32'h2000_0000, "R2");
        rd(25, 32'h0000_0000, "R2");
        wr(4 * 13, 32'h1);
        wr(4 * 20, 32'h1);
        idle(4);
        rd(4 * 13, 32'h0, "R2");
        rd(4 * 20, 32'h0, "R2");
        check32("R2", "empty slot rst", {31'h0, unit_rst[20]}, 32'h1);
        // R8: only bit 0 of write data matters
        phase = "R8";
        wr(28, 32'hFFFF_FFFE);
        idle(4);
        rd(28, 32'h2000_0000, "R8");
        wr(28, 32'h8000_0001);
        idle(8);
        rd(28, 32'h0800_0001, "R8");
        wr(28, 32'hFFFF_FFFE);
        idle(14);
        rd(28, 32'h2000_0000, "R8");
        // R9: idle bus
        phase = "R9";
        bus_addr = AW'(28);
        idle(5);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        if (timed_out) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired got timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule